// File: doc/BRIEF.md
# Toggle-Bit Load Completion Poller

This block sits on the host side of an attached memory whose internal page loads report progress only through a status bit that flips on every read of the buffer being loaded. A requester asks for a load by giving a target buffer number and a command code. The poller writes the command to the memory's command location. It then stays off the bus for a fixed settle interval and reads one address in the chosen buffer again and again. When two reads in a row return the same value of data bit 6, the load is finished and the poller reports done. If the read budget runs out first, it reports a timeout instead.

A cold-start mode covers the time after a power-on reset of the memory, when its interrupt output is still floating and gives no ready indication. In this mode the poller writes nothing and polls the boot buffer (buffer 0) straight away. In both modes the bus is a single-outstanding request/acknowledge link. A request stays asserted until one acknowledge cycle completes it.

Top module: `tbit_poller`

## Requirements
- R1: While and after reset, with no start, `busy_o`, `mem_req_o`, `done_o` and `timeout_o` are all 0.
- R2: A start in idle with `cold_i`=0 and a load code (0000h, 0013h or 00E0h) raises `mem_req_o` with `mem_we_o`=1, `mem_addr_o`=`CMD_ADDR` and `mem_wdata_o` equal to the code in the next cycle. The request is held unchanged until the cycle in which `mem_ack_i` is 1. Exactly one such write happens per load.
- R3: The first poll read request comes exactly SETTLE_CYC cycles after the command's acknowledge cycle, and the request is low in between. SETTLE_CYC = ceil(SETTLE_NS*1000/CLK_PERIOD_PS), which is 35 at the defaults.
- R4: Every poll read has `mem_we_o`=0 and an address with the buffer number in bits [BUF_SHIFT+BUF_W-1:BUF_SHIFT] (bits [10:9] at the defaults) and all other bits 0.
- R5: `done_o` is a one-cycle pulse in the cycle after the acknowledge of a poll read whose bit 6 equals bit 6 of the read before it in the same poll. The first read of a poll never completes it, and data bits other than 6 have no effect.
- R6: If the read numbered MAX_POLLS (64 by default) brings no match, `timeout_o` pulses for one cycle in the next cycle and the poller returns to idle. `done_o` and `timeout_o` are never both high.
- R7: A start with `cold_i`=1 issues no write. It ignores `start_buf_i` and `start_cmd_i` and requests a read of buffer 0 in the next cycle.
- R8: A start with `cold_i`=0 and any other command code is ignored: `busy_o` and `mem_req_o` stay 0.
- R9: `busy_o` is 1 from the cycle after an accepted start until the result pulse. A start while busy has no effect on the buffer polled or the sequence.
- R10: In the cycle of a result pulse `busy_o` is 0, and a start in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load request, sampled while idle |
| cold_i | input | 1 | 1: poll boot buffer without sending a command |
| start_buf_i | input | BUF_W | Buffer to poll |
| start_cmd_i | input | 16 | Load command code |
| busy_o | output | 1 | Sequence in progress |
| mem_req_o | output | 1 | Bus request |
| mem_we_o | output | 1 | 1: write, 0: read |
| mem_addr_o | output | ADDR_W | Bus address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ack_i | input | 1 | Transfer completes in this cycle |
| mem_rdata_i | input | DATA_W | Read data, valid with `mem_ack_i` |
| done_o | output | 1 | Load finished (pulse) |
| timeout_o | output | 1 | Read budget used up (pulse) |

## Verification
The properties assume that the memory raises `mem_ack_i` only while a request is live and for a single cycle per transfer. Under that assumption a held write request and the settle-gap counter in the checker are meaningful. They also assume that a loading buffer flips bit 6 on each acknowledged read and holds it steady once the load ends. The bench memory keeps to this. It raises the acknowledge only against a present request, after a chosen latency, and drops it in the next cycle. It flips bit 6 for a set number of reads and fills every other data bit with random values.

// File: rtl/tbit_pkg.sv
package tbit_pkg;
  localparam int CMD_W      = 16;
  localparam int TOGGLE_BIT = 6;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CMD    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_POLL   = 2'd3
  } tbit_state_e;

  function automatic logic is_load_cmd(input logic [CMD_W-1:0] code);
    return (code == 16'h0000) || (code == 16'h0013) || (code == 16'h00E0);
  endfunction
endpackage

// File: rtl/tbit_settle_timer.sv
module tbit_settle_timer #(
  parameter int CYCLES = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = CW'(CYCLES - 1);
    else if (en_i && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load_i || en_i)
      cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/tbit_toggle_cmp.sv
module tbit_toggle_cmp #(
  parameter int MAX_POLLS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic sample_i,
  input  logic bit_i,
  output logic match_o,
  output logic limit_o
);
  localparam int CNT_W = $clog2(MAX_POLLS + 1);

  logic             prev_q, prev_d;
  logic             have_q, have_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  assign upd_en  = clear_i || sample_i;
  assign match_o = sample_i && have_q && (bit_i == prev_q);
  assign limit_o = sample_i && !match_o && (cnt_q == CNT_W'(MAX_POLLS - 1));

  always_comb begin
    prev_d = prev_q;
    have_d = have_q;
    cnt_d  = cnt_q;
    if (clear_i) begin
      have_d = 1'b0;
      cnt_d  = '0;
    end else if (sample_i) begin
      prev_d = bit_i;
      have_d = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      prev_q <= prev_d;
      have_q <= have_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/tbit_poller.sv
module tbit_poller
  import tbit_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int BUF_W         = 2,
  parameter int BUF_SHIFT     = 9,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int SETTLE_NS     = 350,
  parameter int MAX_POLLS     = 64,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 'hF220
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cold_i,
  input  logic [BUF_W-1:0]  start_buf_i,
  input  logic [CMD_W-1:0]  start_cmd_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              timeout_o
);
  localparam int SETTLE_CYC = (SETTLE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

  tbit_state_e       st_q, st_d;
  logic [BUF_W-1:0]  buf_q, buf_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic              done_q, done_d;
  logic              to_q, to_d;
  logic              start_go, cap_en, xfer;
  logic              tmr_load, tmr_en, tmr_exp;
  logic              cmp_clear, cmp_sample, cmp_match, cmp_limit;
  logic [ADDR_W-1:0] poll_addr;
  logic              unused_rdata;

  assign unused_rdata = ^{mem_rdata_i[DATA_W-1:TOGGLE_BIT+1], mem_rdata_i[TOGGLE_BIT-1:0]};

  assign start_go = start_i && (st_q == ST_IDLE) && (cold_i || is_load_cmd(start_cmd_i));
  assign cap_en   = start_go;
  assign xfer     = mem_req_o && mem_ack_i;

  assign tmr_load   = (st_q == ST_CMD) && xfer;
  assign tmr_en     = (st_q == ST_SETTLE);
  assign cmp_clear  = (st_q != ST_POLL);
  assign cmp_sample = (st_q == ST_POLL) && xfer;

  tbit_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .en_i      (tmr_en),
    .expired_o (tmr_exp)
  );

  tbit_toggle_cmp #(.MAX_POLLS(MAX_POLLS)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (cmp_clear),
    .sample_i (cmp_sample),
    .bit_i    (mem_rdata_i[TOGGLE_BIT]),
    .match_o  (cmp_match),
    .limit_o  (cmp_limit)
  );

  always_comb begin
    st_d   = st_q;
    buf_d  = buf_q;
    cmd_d  = cmd_q;
    done_d = 1'b0;
    to_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_go) begin
          buf_d = cold_i ? '0 : start_buf_i;
          cmd_d = start_cmd_i;
          st_d  = cold_i ? ST_POLL : ST_CMD;
        end
      end
      ST_CMD: begin
        if (xfer) st_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (tmr_exp) st_d = ST_POLL;
      end
      ST_POLL: begin
        if (cmp_match) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (cmp_limit) begin
          to_d = 1'b1;
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      to_q   <= to_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cmd_q <= '0;
    end else if (cap_en) begin
      buf_q <= buf_d;
      cmd_q <= cmd_d;
    end
  end

  always_comb begin
    poll_addr = '0;
    poll_addr[BUF_SHIFT +: BUF_W] = buf_q;
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign mem_req_o   = (st_q == ST_CMD) || (st_q == ST_POLL);
  assign mem_we_o    = (st_q == ST_CMD);
  assign mem_addr_o  = (st_q == ST_CMD) ? CMD_ADDR : poll_addr;
  assign mem_wdata_o = (st_q == ST_CMD) ? DATA_W'(cmd_q) : '0;
  assign done_o      = done_q;
  assign timeout_o   = to_q;
endmodule

// File: rtl/tbit_poller_chk.sv
module tbit_poller_chk #(
  parameter int ADDR_W     = 16,
  parameter int BUF_SHIFT  = 9,
  parameter int SETTLE_CYC = 35
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              done_o,
  input logic              timeout_o
);
  localparam int GW = $clog2(SETTLE_CYC + 2);

  logic          armed_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
    end else if (mem_req_o && mem_we_o && mem_ack_i) begin
      armed_q <= 1'b1;
      gap_q   <= '0;
    end else begin
      if (!mem_req_o && (gap_q < GW'(SETTLE_CYC))) gap_q <= gap_q + 1'b1;
      if (mem_req_o && !mem_we_o) armed_q <= 1'b0;
    end
  end

  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o && !mem_ack_i |=> mem_req_o && mem_we_o && $stable(mem_addr_o));

  // R3
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && mem_req_o && !mem_we_o |-> gap_q >= GW'(SETTLE_CYC));

  // R4
  poll_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_we_o |-> mem_addr_o[BUF_SHIFT-1:0] == '0);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));

  // R10
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || timeout_o) |-> !busy_o);
endmodule

bind tbit_poller tbit_poller_chk #(
  .ADDR_W     (ADDR_W),
  .BUF_SHIFT  (BUF_SHIFT),
  .SETTLE_CYC (SETTLE_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_ack_i  (mem_ack_i),
  .done_o     (done_o),
  .timeout_o  (timeout_o)
);

// File: tb/tbit_poller_bench.sv
`timescale 1ns/1ps
module tbit_poller_bench;
  localparam int SETTLE = 35;
  localparam int MAXP   = 64;
  localparam logic [15:0] CMDA = 16'hF220;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cold = 1'b0;
  logic [1:0]  sbuf = 2'd0;
  logic [15:0] scmd = 16'h0;
  logic        ack = 1'b0;
  logic [15:0] rdata = 16'h0;
  logic        busy_o, mem_req_o, mem_we_o, done_o, timeout_o;
  logic [15:0] mem_addr_o, mem_wdata_o;

  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  tbit_poller u_tbit_poller (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cold_i(cold),
    .start_buf_i(sbuf), .start_cmd_i(scmd), .busy_o(busy_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(ack), .mem_rdata_i(rdata),
    .done_o(done_o), .timeout_o(timeout_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // bench memory: latency, toggling bit 6, transfer monitor
  int  mem_lat = 0, lat = 0, tgl_left = 0;
  bit  tog = 1'b0;
  int  n_wr = 0, n_rd = 0, ack_cyc = 0, rd1_cyc = 0, rd_bad = 0;
  bit  rd_seen = 1'b0;
  logic [15:0] exp_rd_addr = 16'h0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ack = 1'b0; lat = 0;
    end else if (ack) begin
      ack = 1'b0; lat = 0;
    end else if (mem_req_o) begin
      if (!mem_we_o && !rd_seen) begin rd_seen = 1'b1; rd1_cyc = cyc; end
      if (lat >= mem_lat) begin
        ack = 1'b1;
        if (mem_we_o) begin
          n_wr++; ack_cyc = cyc; rdata = 16'($urandom);
        end else begin
          n_rd++;
          if (mem_addr_o !== exp_rd_addr) rd_bad++;
          if (tgl_left > 0) begin tog = ~tog; tgl_left--; end
          rdata = (16'($urandom) & 16'hFFBF) | (tog ? 16'h0040 : 16'h0000);
        end
      end else lat++;
    end
  end

  // behavioural reference, updated per edge, compared every cycle
  int m_ph = 0, m_wait = 0, m_reads = 0;
  bit m_prev = 0, m_have = 0, e_done = 0, e_to = 0;
  logic [1:0]  m_buf = 0;
  logic [15:0] m_cmd = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; e_done = 0; e_to = 0;
    end else begin
      e_done = 0; e_to = 0;
      case (m_ph)
        0: if (start) begin
             if (cold) begin m_ph = 3; m_buf = 0; m_reads = 0; m_have = 0; end
             else if (scmd == 16'h0000 || scmd == 16'h0013 || scmd == 16'h00E0) begin
               m_ph = 1; m_buf = sbuf; m_cmd = scmd;
             end
           end
        1: if (ack) begin m_ph = 2; m_wait = SETTLE; end
        2: begin m_wait--; if (m_wait == 0) begin m_ph = 3; m_reads = 0; m_have = 0; end end
        default: if (ack) begin
             if (m_have && rdata[6] == m_prev) begin e_done = 1; m_ph = 0; end
             else begin
               m_prev = rdata[6]; m_have = 1; m_reads++;
               if (m_reads == MAXP) begin e_to = 1; m_ph = 0; end
             end
           end
      endcase
    end
    #2;
    if (rst_n) begin
      chk("R9 busy", busy_o, m_ph != 0);
      chk("R2 req", mem_req_o, m_ph == 1 || m_ph == 3);
      if (m_ph == 1) begin
        chk("R2 we", mem_we_o, 1);
        chk("R2 addr", mem_addr_o, CMDA);
        chk("R2 wdata", mem_wdata_o, m_cmd);
      end else if (m_ph == 3) begin
        chk("R4 we", mem_we_o, 0);
        chk("R4 addr", mem_addr_o, {5'd0, m_buf, 9'd0});
      end
      chk("R5 done", done_o, e_done);
      chk("R6 timeout", timeout_o, e_to);
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic prep(input int tgl, input int l, input logic [15:0] ea);
    tgl_left = tgl; mem_lat = l; exp_rd_addr = ea;
    n_wr = 0; n_rd = 0; rd_bad = 0; rd_seen = 1'b0;
  endtask

  task automatic do_start(input bit c, input logic [1:0] b, input logic [15:0] k);
    @(negedge clk); start = 1'b1; cold = c; sbuf = b; scmd = k;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end(output bit d, output bit t);
    int n = 0;
    d = 0; t = 0;
    while (!(done_o || timeout_o) && n < 6000) begin @(negedge clk); n++; end
    d = done_o; t = timeout_o;
    chk("R10 idle at result", busy_o, 0);
  endtask

  initial begin
    bit d, t;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 req in reset", mem_req_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 req", mem_req_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 timeout", timeout_o, 0);

    // normal load, buffer 1
    prep(5, 0, 16'h0200);
    do_start(0, 2'd1, 16'h0013);
    wait_end(d, t);
    chk("R5 done seen", d, 1);
    chk("R5 reads to finish", n_rd, 6);
    chk("R2 one write", n_wr, 1);
    chk("R3 settle gap", rd1_cyc - ack_cyc - 1, SETTLE);
    chk("R4 read addr", rd_bad, 0);

    // already-finished load, slow bus, buffer 2
    prep(0, 3, 16'h0400);
    do_start(0, 2'd2, 16'h0000);
    wait_end(d, t);
    chk("R5 two reads", n_rd, 2);
    chk("R3 settle gap slow bus", rd1_cyc - ack_cyc - 1, SETTLE);

    // never-finishing load
    prep(1000, 0, 16'h0600);
    do_start(0, 2'd3, 16'h00E0);
    wait_end(d, t);
    chk("R6 timeout seen", t, 1);
    chk("R6 no done", d, 0);
    chk("R6 read budget", n_rd, MAXP);

    // other command code
    prep(0, 0, 16'h0000);
    do_start(0, 2'd1, 16'h0012);
    repeat (20) begin
      @(negedge clk);
      chk("R8 no busy", busy_o, 0);
    end
    chk("R8 no write", n_wr, 0);

    // cold mode
    prep(3, 1, 16'h0000);
    do_start(1, 2'd2, 16'h1234);
    chk("R7 polling at once", mem_req_o & ~mem_we_o, 1);
    wait_end(d, t);
    chk("R7 no write", n_wr, 0);
    chk("R7 reads", n_rd, 4);
    chk("R7 boot addr", rd_bad, 0);

    // start while busy
    prep(10, 0, 16'h0200);
    do_start(0, 2'd1, 16'h0013);
    repeat (4) @(negedge clk);
    start = 1'b1; cold = 1'b1; sbuf = 2'd2;
    @(negedge clk); start = 1'b0; cold = 1'b0;
    wait_end(d, t);
    chk("R9 sequence kept", n_rd, 11);
    chk("R9 buffer kept", rd_bad, 0);

    // back-to-back: start in the result cycle
    prep(2, 0, 16'h0400);
    do_start(0, 2'd2, 16'h0000);
    wait_end(d, t);
    tgl_left = 1; n_rd = 0; n_wr = 0;
    start = 1'b1; cold = 1'b0; sbuf = 2'd2; scmd = 16'h00E0;
    @(negedge clk); start = 1'b0;
    chk("R10 restart accepted", busy_o, 1);
    wait_end(d, t);
    chk("R10 second done", d, 1);
    chk("R10 second write", n_wr, 1);

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule